// File: doc/BRIEF.md
# Dual Data Pointer Bank with Auxiliary Control Register

This block sits in the special-function register space of a small CPU. It holds two 16-bit data pointers and one 8-bit auxiliary control register. Bit 0 of the control register picks which pointer is active. The active pointer is driven onto `ptr_value` for the address datapath. The datapath can load the active pointer with a full 16-bit value or increment it. Software can read and write its low and high bytes through a simple byte bus made of an address, a write strobe and write data. Reads are combinational.

Bits 1 and 2 of the control register are wired to zero, so the carry from bit 0 stops there. A CPU can therefore switch pointers with a single read-modify-write increment of the control register, and no other control bit changes. Bit 3 is a software-reset strobe. Writing a 1 to it raises a one-cycle system reset request and returns every pointer and register bit to zero at the same edge. Bits 7 to 4 are plain read/write flags.

Top module: `dptr_aux_ctrl`

## Requirements
- R1: Bit 0 of the control register (address 0x10) selects the active pointer: 0 selects pointer 0 and 1 selects pointer 1. After a control write, `ptr_sel` equals that bit and `ptr_value` shows the selected pointer.
- R2: Control bits 2 and 1 always read as zero and ignore writes. Bit 3 also reads as zero.
- R3: Reading the control register, adding one and writing the result back inverts bit 0 and leaves bits 7 to 4 unchanged, in both directions.
- R4: Writing the control register with bit 3 set drives `swrst_req` high for exactly the one cycle after that write edge. When the write is followed by a write without bit 3, `swrst_req` is low again on the next cycle.
- R5: `ptr_op` 2'b01 loads `ptr_load` into the active pointer. 2'b10 increments the active pointer by one, wrapping from 0xFFFF to 0x0000. 2'b00 and 2'b11 do nothing.
- R6: A write to address 0x11 replaces the low byte of the active pointer, and a write to 0x12 replaces its high byte. Reads of these addresses return those bytes. The other byte keeps its value.
- R7: The unselected pointer keeps its value through every pointer operation and byte write.
- R8: Hardware reset, and the edge of a software-reset write, clear both pointers, the select bit and the flag bits to zero.
- R9: A bus byte write to the active pointer in the same cycle as a datapath operation wins, and the operation is dropped.
- R10: Control bits 7 to 4 are read/write flags with no other effect. Reads of any unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ptr_op | input | 2 | Datapath operation: 00 none, 01 load, 10 increment, 11 none |
| ptr_load | input | 16 | Value for a load operation |
| ptr_value | output | 16 | Active pointer |
| ptr_sel | output | 1 | Active pointer index |
| swrst_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets the increment-toggle path with the flag bits set. A design that stored bit 1 would land on pointer 0 with a stray bit set instead of toggling. A design whose carry reached bit 3 would fire a software reset.

It drives a pointer past 0xFFFF to catch a wrong wrap. It issues a byte write together with a load in the same cycle, which exposes a design that lets the datapath win. It checks the unselected pointer after switching pointers, which shows whether an operation leaked into the wrong bank. The software-reset case checks that the request lasts one cycle and that all state comes back cleared.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   typedef enum logic [1:0] {
      PTR_IDLE = 2'b00,
      PTR_LOAD = 2'b01,
      PTR_INC  = 2'b10,
      PTR_RSVD = 2'b11
   } ptr_op_e;
endpackage

// File: rtl/dpa_aux_reg.sv
module dpa_aux_reg #(
   parameter int                DATA_W    = 8,
   parameter int                SEL_BIT   = 0,
   parameter int                SRST_BIT  = 3,
   parameter logic [DATA_W-1:0] ZERO_MASK = 8'h06
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aux_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] aux_rd,
   output logic              sel,
   output logic              soft_clr,
   output logic              swrst_req
);
   localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;
   localparam logic [DATA_W-1:0] WR_MASK   = ~(ZERO_MASK | SRST_MASK);

   // Increment toggling relies on the bit above the select bit being tied low.
   if (SRST_BIT >= DATA_W || SEL_BIT + 1 >= DATA_W) begin : g_bad_bits
      $error("dpa_aux_reg: bit position outside register");
   end
   if (ZERO_MASK[SEL_BIT] || !ZERO_MASK[SEL_BIT+1] || SRST_BIT == SEL_BIT) begin : g_bad_mask
      $error("dpa_aux_reg: select bit needs a tied-low neighbour above it");
   end

   logic [DATA_W-1:0] aux_q;
   logic              swrst_q;

   assign soft_clr = aux_wr && wdata[SRST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_q   <= '0;
         swrst_q <= 1'b0;
      end else begin
         swrst_q <= soft_clr;
         if (soft_clr)    aux_q <= '0;
         else if (aux_wr) aux_q <= wdata & WR_MASK;
      end
   end

   assign aux_rd    = aux_q;
   assign sel       = aux_q[SEL_BIT];
   assign swrst_req = swrst_q;
endmodule

// File: rtl/dpa_ptr_slot.sv
module dpa_ptr_slot
   import dpa_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              active,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  ptr_op_e           op,
   input  logic [PTR_W-1:0]  load_val,
   output logic [PTR_W-1:0]  ptr_q
);
   if (PTR_W != 2 * DATA_W) begin : g_bad_width
      $error("dpa_ptr_slot: pointer must be two bytes wide");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (soft_clr) begin
         ptr_q <= '0;
      end else if (active) begin
         if (wr_lo || wr_hi) begin
            if (wr_lo) ptr_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) ptr_q[PTR_W-1:DATA_W] <= wdata;
         end else begin
            case (op)
               PTR_LOAD: ptr_q <= load_val;
               PTR_INC:  ptr_q <= ptr_q + PTR_W'(1);
               default:  ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dpa_rd_mux.sv
module dpa_rd_mux #(
   parameter int                DATA_W  = 8,
   parameter int                PTR_W   = 16,
   parameter int                ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] A_AUX   = 8'h10,
   parameter logic [ADDR_W-1:0] A_LO    = 8'h11,
   parameter logic [ADDR_W-1:0] A_HI    = 8'h12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] aux_rd,
   input  logic [PTR_W-1:0]  act_ptr,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      if (addr == A_AUX)     rdata = aux_rd;
      else if (addr == A_LO) rdata = act_ptr[DATA_W-1:0];
      else if (addr == A_HI) rdata = act_ptr[PTR_W-1:DATA_W];
      else                   rdata = '0;
   end
endmodule

// File: rtl/dptr_aux_ctrl.sv
module dptr_aux_ctrl
   import dpa_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 8,
   parameter int                SRST_BIT  = 3,
   parameter logic [ADDR_W-1:0] A_AUX     = 8'h10,
   parameter logic [ADDR_W-1:0] A_LO      = 8'h11,
   parameter logic [ADDR_W-1:0] A_HI      = 8'h12,
   parameter logic [DATA_W-1:0] ZERO_MASK = 8'h06
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [1:0]          ptr_op,
   input  logic [2*DATA_W-1:0] ptr_load,
   output logic [2*DATA_W-1:0] ptr_value,
   output logic                ptr_sel,
   output logic                swrst_req
);
   localparam int PTR_W = 2 * DATA_W;
   localparam int N_PTR = 2;

   if (A_AUX == A_LO || A_AUX == A_HI || A_LO == A_HI) begin : g_bad_addr
      $error("dptr_aux_ctrl: register addresses must differ");
   end

   logic [DATA_W-1:0] aux_rd;
   logic              soft_clr;
   logic              aux_wr, lo_wr, hi_wr;
   logic [PTR_W-1:0]  ptr_arr [N_PTR];
   ptr_op_e           op_e;

   assign op_e   = ptr_op_e'(ptr_op);
   assign aux_wr = bus_we && (bus_addr == A_AUX);
   assign lo_wr  = bus_we && (bus_addr == A_LO);
   assign hi_wr  = bus_we && (bus_addr == A_HI);

   dpa_aux_reg #(
      .DATA_W(DATA_W), .SEL_BIT(0), .SRST_BIT(SRST_BIT), .ZERO_MASK(ZERO_MASK)
   ) u_aux (
      .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .wdata(bus_wdata),
      .aux_rd(aux_rd), .sel(ptr_sel), .soft_clr(soft_clr), .swrst_req(swrst_req)
   );

   for (genvar i = 0; i < N_PTR; i++) begin : g_slot
      dpa_ptr_slot #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
         .active(ptr_sel == i[0]),
         .wr_lo(lo_wr), .wr_hi(hi_wr), .wdata(bus_wdata),
         .op(op_e), .load_val(ptr_load), .ptr_q(ptr_arr[i])
      );
   end

   assign ptr_value = ptr_arr[ptr_sel];

   dpa_rd_mux #(
      .DATA_W(DATA_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W),
      .A_AUX(A_AUX), .A_LO(A_LO), .A_HI(A_HI)
   ) u_rd (
      .addr(bus_addr), .aux_rd(aux_rd), .act_ptr(ptr_value), .rdata(bus_rdata)
   );
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
   parameter int                DATA_W   = 8,
   parameter int                ADDR_W   = 8,
   parameter int                SRST_BIT = 3,
   parameter logic [ADDR_W-1:0] A_AUX    = 8'h10,
   parameter logic [ADDR_W-1:0] A_LO     = 8'h11
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [1:0]          ptr_op,
   input logic [2*DATA_W-1:0] ptr_load,
   input logic [2*DATA_W-1:0] ptr_value,
   input logic                ptr_sel,
   input logic                swrst_req,
   input logic [2*DATA_W-1:0] ptr0,
   input logic [2*DATA_W-1:0] ptr1
);
   logic aux_plain_wr, aux_srst_wr;
   assign aux_plain_wr = bus_we && bus_addr == A_AUX && !bus_wdata[SRST_BIT];
   assign aux_srst_wr  = bus_we && bus_addr == A_AUX &&  bus_wdata[SRST_BIT];

   p_sel_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      aux_plain_wr |=> ptr_sel == $past(bus_wdata[0]));

   p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_AUX) |-> (bus_rdata[2:1] == 2'b00 && !bus_rdata[SRST_BIT]));

   p_swrst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      aux_srst_wr |=> swrst_req);

   p_swrst_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_srst_wr |=> !swrst_req);

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && ptr_op == 2'b01) |=> ptr_value == $past(ptr_load));

   p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && ptr_op == 2'b10) |=> ptr_value == $past(ptr_value) + 1'b1);

   p_lo_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_LO) |=>
         (ptr_value[DATA_W-1:0] == $past(bus_wdata) &&
          ptr_value[2*DATA_W-1:DATA_W] == $past(ptr_value[2*DATA_W-1:DATA_W])));

   p_hold0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!aux_srst_wr && !aux_plain_wr && ptr_sel) |=> $stable(ptr0));

   p_hold1_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!aux_srst_wr && !aux_plain_wr && !ptr_sel) |=> $stable(ptr1));

   p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_req |-> (ptr0 == '0 && ptr1 == '0 && !ptr_sel));
endmodule

bind dptr_aux_ctrl dpa_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRST_BIT(SRST_BIT), .A_AUX(A_AUX), .A_LO(A_LO)
) u_dpa_checker (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ptr_op(ptr_op),
   .ptr_load(ptr_load), .ptr_value(ptr_value), .ptr_sel(ptr_sel),
   .swrst_req(swrst_req), .ptr0(ptr_arr[0]), .ptr1(ptr_arr[1])
);

// File: tb/dptr_aux_ctrl_bench.sv
`timescale 1ns/100ps
module dptr_aux_ctrl_bench;
   localparam logic [7:0] A_AUX = 8'h10, A_LO = 8'h11, A_HI = 8'h12, A_NONE = 8'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [1:0]  ptr_op = '0;
   logic [15:0] ptr_load = '0;
   logic [15:0] ptr_value;
   logic        ptr_sel;
   logic        swrst_req;

   int n_checks = 0;
   int n_fail   = 0;

   // reference state
   logic [15:0] m_p [2];
   logic        m_sel;
   logic [3:0]  m_flags;
   logic        m_srst;

   always #2.5 clk = ~clk;

   dptr_aux_ctrl u_dptr_aux_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ptr_op(ptr_op),
      .ptr_load(ptr_load), .ptr_value(ptr_value), .ptr_sel(ptr_sel),
      .swrst_req(swrst_req)
   );

   function automatic logic [7:0] model_rd(input logic [7:0] a);
      if (a == A_AUX) return {m_flags, 3'b000, m_sel};
      if (a == A_LO)  return m_p[m_sel][7:0];
      if (a == A_HI)  return m_p[m_sel][15:8];
      return 8'h00;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_p[0] = '0; m_p[1] = '0; m_sel = 1'b0; m_flags = '0; m_srst = 1'b0;
   endtask

   task automatic model_step(input logic [7:0] a, input logic we, input logic [7:0] wd,
                             input logic [1:0] op, input logic [15:0] ld);
      m_srst = 1'b0;
      if (we && a == A_AUX && wd[3]) begin
         model_reset();
         m_srst = 1'b1;
      end else begin
         if (we && a == A_LO)      m_p[m_sel][7:0]  = wd;
         else if (we && a == A_HI) m_p[m_sel][15:8] = wd;
         else if (op == 2'b01)     m_p[m_sel] = ld;
         else if (op == 2'b10)     m_p[m_sel] = m_p[m_sel] + 16'd1;
         if (we && a == A_AUX) begin
            m_sel   = wd[0];
            m_flags = wd[7:4];
         end
      end
   endtask

   // one clock: drive at negedge, check read data, advance, check state outputs
   task automatic cyc(input string tag, input logic [7:0] a, input logic we,
                      input logic [7:0] wd, input logic [1:0] op, input logic [15:0] ld);
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_wdata = wd; ptr_op = op; ptr_load = ld;
      #0.5;
      check(tag, "bus_rdata", int'(bus_rdata), int'(model_rd(a)));
      model_step(a, we, wd, op, ld);
      @(posedge clk);
      #0.5;
      check(tag, "ptr_value", int'(ptr_value), int'(m_p[m_sel]));
      check(tag, "ptr_sel",   int'(ptr_sel),   int'(m_sel));
      check(tag, "swrst_req", int'(swrst_req), int'(m_srst));
   endtask

   task automatic rd(input string tag, input logic [7:0] a);
      cyc(tag, a, 1'b0, 8'h00, 2'b00, 16'h0000);
   endtask

   // read-modify-write increment of the control register, using the port value
   task automatic rmw_inc(input string tag);
      logic [7:0] v;
      @(negedge clk);
      bus_addr = A_AUX; bus_we = 1'b0; ptr_op = 2'b00;
      #0.5;
      v = bus_rdata;
      cyc(tag, A_AUX, 1'b1, v + 8'd1, 2'b00, 16'h0000);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      model_reset();
      repeat (3) @(posedge clk);
      #0.5;
      check("R8", "reset ptr_value", int'(ptr_value), 0);
      check("R8", "reset swrst_req", int'(swrst_req), 0);
      @(negedge clk); rst_n = 1'b1;

      rd("R8", A_AUX);
      // R5: load and increment pointer 0, reserved op does nothing
      cyc("R5", A_NONE, 1'b0, 8'h00, 2'b01, 16'h1234);
      cyc("R5", A_NONE, 1'b0, 8'h00, 2'b10, 16'h0000);
      cyc("R5", A_NONE, 1'b0, 8'h00, 2'b11, 16'hBEEF);
      // R3 / R1: toggle to pointer 1 by increment
      rmw_inc("R3");
      rd("R7", A_LO);
      cyc("R5", A_NONE, 1'b0, 8'h00, 2'b01, 16'hFFFE);
      cyc("R5", A_NONE, 1'b0, 8'h00, 2'b10, 16'h0000);
      cyc("R5", A_NONE, 1'b0, 8'h00, 2'b10, 16'h0000);  // wrap to 0000
      // R6: byte writes on pointer 1
      cyc("R6", A_LO, 1'b1, 8'hA5, 2'b00, 16'h0000);
      cyc("R6", A_HI, 1'b1, 8'h3C, 2'b00, 16'h0000);
      rd("R6", A_LO);
      rd("R6", A_HI);
      // R9: byte write wins over simultaneous load
      cyc("R9", A_HI, 1'b1, 8'h77, 2'b01, 16'hDEAD);
      // R2 / R10: write flags plus tied bits, keep select 1
      cyc("R2", A_AUX, 1'b1, 8'hF7 & 8'hF7, 2'b00, 16'h0000);
      rd("R2", A_AUX);
      rd("R10", A_NONE);
      // R3: toggle back with flags set, then forward again
      rmw_inc("R3");
      rd("R3", A_AUX);
      rd("R7", A_LO);
      rmw_inc("R3");
      rd("R3", A_AUX);
      cyc("R1", A_AUX, 1'b1, 8'h50, 2'b10, 16'h0000);  // op hits old selection
      rd("R7", A_HI);
      // R4 / R8: software reset, then quiet cycle
      cyc("R4", A_AUX, 1'b1, 8'h08, 2'b00, 16'h0000);
      rd("R4", A_AUX);
      rd("R8", A_LO);
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         logic [7:0] a;
         logic [7:0] wd;
         int r;
         r  = $urandom_range(0, 3);
         a  = (r == 0) ? A_AUX : (r == 1) ? A_LO : (r == 2) ? A_HI : A_NONE;
         wd = 8'($urandom);
         if ($urandom_range(0, 30) != 0) wd[3] = 1'b0;
         cyc("R7", a, 1'($urandom), wd, 2'($urandom), 16'($urandom));
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule